// File: doc/BRIEF.md
# Power-management bus command channel

This block is one host-facing command channel for a two-wire power-management bus. Software stages up to eight outgoing data bytes in two 32-bit lane registers. It then writes a single command word that names an operation, a slave, a 16-bit register address and a byte count. That write hands the transaction to a transaction-port stub with a one-cycle request pulse. The answer returns on a response strobe with a result code and up to eight bytes of read data. The block keeps the valid read bytes and reports the outcome in a status register.

Control is a three-state machine:
- **S_IDLE** waits for a command write. The transition *accept* moves it to S_ISSUE.
- **S_ISSUE** lasts one cycle. If the opcode is defined and the reserved bits are zero, it pulses the request and takes the transition *launch* to S_WAIT. Otherwise it takes the transition *reject* straight back to S_IDLE with done and failure set.
- **S_WAIT** counts cycles. It returns to S_IDLE on *answer*, when the response strobe arrives, or on *expire*, when the programmed cycle budget runs out.

Host registers are addressed by word index. The byte offset is four times the index.

| Index | Register |
|---|---|
| 0 | command |
| 1 | timeout budget |
| 2 | status |
| 4 | write lane 0 |
| 5 | write lane 1 |
| 6 | read lane 0 |
| 7 | read lane 1 |

Index 3 reads as zero.

The command word has these fields:
- bits 31:27: opcode
- bits 26:24: reserved, must be zero
- bits 23:20: slave
- bits 19:4: address
- bit 3: reserved, must be zero
- bits 2:0: byte count minus one

Byte k of a transaction sits in lane k/4, at bits 8*(k%4)+7 : 8*(k%4).

Top module: `pbus_cmd_chan`

## Requirements
- R1: A command write (csr_we with csr_addr 0) in S_IDLE produces exactly one txn_req cycle, in the cycle after the write edge. During that cycle txn_opcode, txn_slave, txn_addr and txn_bcnt carry command bits 31:27, 23:20, 19:4 and 2:0.
- R2: During txn_req, txn_wdata is {lane1, lane0} with every byte above the byte count forced to zero. The lanes must be loaded before the command write.
- R3: An accepted command clears both read lanes. Only a read opcode (1, 13 or 15) answered with code 0 in time loads them, with rsp_rdata masked to the byte count. Read lanes stay zero while a transaction is pending.
- R4: Status bit 0 is done, bit 1 failure, bit 2 denied and bit 3 dropped. An accepted command clears all four. No error bit is ever set without done.
- R5: A response code maps to the status as follows: 0 gives 0x1, 1 (not permitted) gives 0x5, 2 (collision lost) gives 0x9, and 3 (bus fault) gives 0x3. At most one error bit is set.
- R6: Register 1 holds a budget N, reset value TMO_RESET. If no response arrives in the first max(N,1) cycles of S_WAIT, status becomes 0x3. With response delay d (0 meaning the first S_WAIT cycle), done becomes visible d+2 cycles after the command write edge, or N+1 cycles after it on expiry.
- R7: While a transaction is pending, a command write is ignored. The command register, status and request line are unaffected.
- R8: Non-data opcodes 3 to 6 (reset, sleep, shutdown, wakeup) raise txn_nondata and drive txn_addr, txn_bcnt and txn_wdata to zero.
- R9: Undefined opcodes (7 to 12, 17 to 31) and nonzero reserved bits issue no request. Status becomes 0x3 one cycle after the command write.
- R10: After reset, every register reads zero except the budget, which reads TMO_RESET, and txn_req is low.
- R11: Host writes to status and the read lanes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| csr_we | input | 1 | host register write strobe |
| csr_addr | input | 3 | host register word index |
| csr_wdata | input | 32 | host write data |
| csr_rdata | output | 32 | host read data for csr_addr (combinational) |
| txn_req | output | 1 | one-cycle transaction request to the port stub |
| txn_opcode | output | 5 | transaction opcode |
| txn_slave | output | 4 | slave identifier |
| txn_addr | output | 16 | register address on the slave |
| txn_bcnt | output | 3 | byte count minus one |
| txn_nondata | output | 1 | request is a non-data command |
| txn_wdata | output | 64 | masked outgoing data bytes |
| rsp_valid | input | 1 | response strobe from the port stub |
| rsp_code | input | 2 | 0 ok, 1 not permitted, 2 collision lost, 3 bus fault |
| rsp_rdata | input | 64 | returned data bytes |

## Verification
A stuck or misrouted state shows on the ports within a few cycles.
- A machine left outside S_IDLE leaves done low and swallows the next command, so the R7 and polling checks fail on the following transaction.
- An off-by-one budget counter shifts the cycle at which done appears, and the per-transaction latency check catches that.
- A wrong lane mask or a stale read lane shows in the very next readback of the read registers, or in the stub's copy of the outgoing bytes.

// File: rtl/pbus_cmd_pkg.sv
package pbus_cmd_pkg;

    localparam int NBYTES  = 8;
    localparam int DATA_W  = NBYTES * 8;
    localparam int BCNT_W  = $clog2(NBYTES);
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 3;

    // host register word indices
    localparam logic [IDX_W-1:0] IDX_CMD  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CFG  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_STAT = 3'd2;
    localparam logic [IDX_W-1:0] IDX_WL0  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_WL1  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_RL0  = 3'd6;
    localparam logic [IDX_W-1:0] IDX_RL1  = 3'd7;

    typedef enum logic [4:0] {
        OP_XWR_LONG  = 5'd0,
        OP_XRD_LONG  = 5'd1,
        OP_XWR       = 5'd2,
        OP_BUS_RESET = 5'd3,
        OP_SLEEP     = 5'd4,
        OP_SHUTDOWN  = 5'd5,
        OP_WAKE      = 5'd6,
        OP_XRD       = 5'd13,
        OP_WR        = 5'd14,
        OP_RD        = 5'd15,
        OP_ZERO_WR   = 5'd16
    } op_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_DENY  = 2'd1,
        RSP_LOST  = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } fsm_e;

    // status values: bit0 done, bit1 failure, bit2 denied, bit3 dropped
    localparam logic [3:0] FLG_OK      = 4'b0001;
    localparam logic [3:0] FLG_FAILED  = 4'b0011;
    localparam logic [3:0] FLG_DENIED  = 4'b0101;
    localparam logic [3:0] FLG_DROPPED = 4'b1001;

endpackage

// File: rtl/pbus_cmd_decode.sv
module pbus_cmd_decode
    import pbus_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output logic [4:0]        opcode,
    output logic [3:0]        slave,
    output logic [15:0]       addr,
    output logic [BCNT_W-1:0] bcnt,
    output logic              op_ok,
    output logic              is_read,
    output logic              is_nondata,
    output logic [DATA_W-1:0] lane_mask
);

    logic              op_known;
    logic              resv_zero;
    logic [BCNT_W-1:0] bcnt_eff;

    assign opcode    = cmd_word[31:27];
    assign slave     = cmd_word[23:20];
    assign addr      = cmd_word[19:4];
    assign bcnt      = cmd_word[2:0];
    assign resv_zero = (cmd_word[26:24] == 3'b000) && !cmd_word[3];

    always_comb begin
        op_known   = 1'b0;
        is_read    = 1'b0;
        is_nondata = 1'b0;
        unique case (opcode)
            OP_XWR_LONG, OP_XWR, OP_WR, OP_ZERO_WR: op_known = 1'b1;
            OP_XRD_LONG, OP_XRD, OP_RD: begin
                op_known = 1'b1;
                is_read  = 1'b1;
            end
            OP_BUS_RESET, OP_SLEEP, OP_SHUTDOWN, OP_WAKE: begin
                op_known   = 1'b1;
                is_nondata = 1'b1;
            end
            default: op_known = 1'b0;
        endcase
    end

    assign op_ok    = op_known && resv_zero;
    assign bcnt_eff = is_nondata ? '0 : bcnt;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] =
            (!is_nondata && (g <= int'(bcnt_eff))) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/pbus_cmd_fsm.sv
module pbus_cmd_fsm
    import pbus_cmd_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_ok,
    input  logic             rsp_valid,
    input  logic [1:0]       rsp_code,
    input  logic [TMO_W-1:0] limit,
    output logic             busy,
    output logic             req,
    output logic             fin,
    output logic [3:0]       fin_flags
);

    localparam int CW = TMO_W + 1;

    fsm_e             state_q, state_d;
    logic [TMO_W-1:0] cnt_q;
    logic             expire;

    assign expire = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, limit};

    // state register and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == S_WAIT) ? cnt_q + TMO_W'(1) : '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_ISSUE;
            S_ISSUE: state_d = op_ok ? S_WAIT : S_IDLE;
            S_WAIT:  if (rsp_valid || expire) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        req       = 1'b0;
        fin       = 1'b0;
        fin_flags = 4'b0000;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_ISSUE: begin
                req = op_ok;
                if (!op_ok) begin
                    fin       = 1'b1;
                    fin_flags = FLG_FAILED;
                end
            end
            S_WAIT: begin
                if (rsp_valid) begin
                    fin = 1'b1;
                    unique case (rsp_code)
                        RSP_OK:   fin_flags = FLG_OK;
                        RSP_DENY: fin_flags = FLG_DENIED;
                        RSP_LOST: fin_flags = FLG_DROPPED;
                        default:  fin_flags = FLG_FAILED;
                    endcase
                end else if (expire) begin
                    fin       = 1'b1;
                    fin_flags = FLG_FAILED;
                end
            end
            default: busy = 1'b0;
        endcase
    end

    assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    assert_expire_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !rsp_valid && expire) |=> (state_q == S_IDLE));

endmodule

// File: rtl/pbus_cmd_regs.sv
module pbus_cmd_regs
    import pbus_cmd_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [IDX_W-1:0]  csr_addr,
    input  logic [WORD_W-1:0] csr_wdata,
    output logic [WORD_W-1:0] csr_rdata,
    input  logic              accept,
    input  logic              fin,
    input  logic [3:0]        fin_flags,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_value,
    output logic [WORD_W-1:0] cmd_q,
    output logic [TMO_W-1:0]  limit_q,
    output logic [DATA_W-1:0] wlane_q,
    output logic [DATA_W-1:0] rlane_q,
    output logic [3:0]        stat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            limit_q <= TMO_W'(TMO_RESET);
            wlane_q <= '0;
            rlane_q <= '0;
            stat_q  <= '0;
        end else begin
            if (csr_we && csr_addr == IDX_CFG) limit_q <= csr_wdata[TMO_W-1:0];
            if (csr_we && csr_addr == IDX_WL0) wlane_q[31:0]  <= csr_wdata;
            if (csr_we && csr_addr == IDX_WL1) wlane_q[63:32] <= csr_wdata;
            if (accept) begin
                cmd_q   <= csr_wdata;
                stat_q  <= '0;
                rlane_q <= '0;
            end else begin
                if (fin)     stat_q  <= fin_flags;
                if (rd_load) rlane_q <= rd_value;
            end
        end
    end

    always_comb begin
        unique case (csr_addr)
            IDX_CMD:  csr_rdata = cmd_q;
            IDX_CFG:  csr_rdata = WORD_W'(limit_q);
            IDX_STAT: csr_rdata = WORD_W'(stat_q);
            IDX_WL0:  csr_rdata = wlane_q[31:0];
            IDX_WL1:  csr_rdata = wlane_q[63:32];
            IDX_RL0:  csr_rdata = rlane_q[31:0];
            IDX_RL1:  csr_rdata = rlane_q[63:32];
            default:  csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbus_cmd_chan.sv
module pbus_cmd_chan
    import pbus_cmd_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [2:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        txn_req,
    output logic [4:0]  txn_opcode,
    output logic [3:0]  txn_slave,
    output logic [15:0] txn_addr,
    output logic [2:0]  txn_bcnt,
    output logic        txn_nondata,
    output logic [63:0] txn_wdata,
    input  logic        rsp_valid,
    input  logic [1:0]  rsp_code,
    input  logic [63:0] rsp_rdata
);

    logic              cmd_we, accept, busy, fin, rd_load;
    logic [3:0]        fin_flags, stat_q;
    logic [WORD_W-1:0] cmd_q;
    logic [TMO_W-1:0]  limit_q;
    logic [DATA_W-1:0] wlane_q, rlane_q, lane_mask;
    logic [4:0]        d_op;
    logic [3:0]        d_slave;
    logic [15:0]       d_addr;
    logic [BCNT_W-1:0] d_bcnt;
    logic              d_ok, d_read, d_nondata;

    assign cmd_we  = csr_we && (csr_addr == IDX_CMD);
    assign accept  = cmd_we && !busy;
    assign rd_load = fin && (fin_flags == FLG_OK) && d_read;

    pbus_cmd_decode u_dec (
        .cmd_word   (cmd_q),
        .opcode     (d_op),
        .slave      (d_slave),
        .addr       (d_addr),
        .bcnt       (d_bcnt),
        .op_ok      (d_ok),
        .is_read    (d_read),
        .is_nondata (d_nondata),
        .lane_mask  (lane_mask)
    );

    pbus_cmd_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .accept    (accept),
        .fin       (fin),
        .fin_flags (fin_flags),
        .rd_load   (rd_load),
        .rd_value  (rsp_rdata & lane_mask),
        .cmd_q     (cmd_q),
        .limit_q   (limit_q),
        .wlane_q   (wlane_q),
        .rlane_q   (rlane_q),
        .stat_q    (stat_q)
    );

    pbus_cmd_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .op_ok     (d_ok),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .limit     (limit_q),
        .busy      (busy),
        .req       (txn_req),
        .fin       (fin),
        .fin_flags (fin_flags)
    );

    assign txn_opcode  = d_op;
    assign txn_slave   = d_slave;
    assign txn_addr    = d_nondata ? '0 : d_addr;
    assign txn_bcnt    = d_nondata ? '0 : d_bcnt;
    assign txn_nondata = d_nondata;
    assign txn_wdata   = wlane_q & lane_mask;

    assert_err_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_q[3:1]) |-> stat_q[0]);

    assert_single_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat_q[3:1]) <= 1);

    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> $stable(cmd_q));

    assert_rlane_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rlane_q == '0));

    assert_req_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_req |-> d_ok);

endmodule

// File: tb/pbus_cmd_chan_bench.sv
module pbus_cmd_chan_bench;

    localparam int TMO_RESET = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        txn_req, txn_nondata;
    logic [4:0]  txn_opcode;
    logic [3:0]  txn_slave;
    logic [15:0] txn_addr;
    logic [2:0]  txn_bcnt;
    logic [63:0] txn_wdata;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_code = '0;
    logic [63:0] rsp_rdata = '0;

    always #10 clk = ~clk;

    pbus_cmd_chan #(.TMO_W(16), .TMO_RESET(TMO_RESET)) u_pbus_cmd_chan (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .txn_req(txn_req),
        .txn_opcode(txn_opcode), .txn_slave(txn_slave), .txn_addr(txn_addr),
        .txn_bcnt(txn_bcnt), .txn_nondata(txn_nondata), .txn_wdata(txn_wdata),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    // port stub model
    int          stub_delay = 0;
    bit          stub_silent = 0;
    logic [1:0]  stub_code = '0;
    logic [63:0] stub_data = '0;
    bit          stub_armed = 0;
    int          stub_cnt = 0;
    int          req_count = 0;
    logic [4:0]  cap_op;
    logic [3:0]  cap_slave;
    logic [15:0] cap_addr;
    logic [2:0]  cap_bcnt;
    logic        cap_nd;
    logic [63:0] cap_wdata;

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (stub_armed) begin
            if (stub_cnt == 0) begin
                rsp_valid  = 1'b1;
                rsp_code   = stub_code;
                rsp_rdata  = stub_data;
                stub_armed = 0;
            end else begin
                stub_cnt--;
            end
        end
        if (txn_req) begin
            req_count++;
            cap_op = txn_opcode; cap_slave = txn_slave; cap_addr = txn_addr;
            cap_bcnt = txn_bcnt; cap_nd = txn_nondata; cap_wdata = txn_wdata;
            if (!stub_silent) begin
                stub_armed = 1;
                stub_cnt   = stub_delay;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [2:0] a, output logic [31:0] v);
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    function automatic logic [63:0] lane_mask(input logic [2:0] bc);
        logic [63:0] m = '0;
        for (int i = 0; i < 8; i++) if (i <= int'(bc)) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic bit op_defined(input logic [4:0] op);
        return (op <= 5'd6) || (op >= 5'd13 && op <= 5'd16);
    endfunction

    function automatic bit op_nondata(input logic [4:0] op);
        return (op >= 5'd3 && op <= 5'd6);
    endfunction

    function automatic bit op_read(input logic [4:0] op);
        return (op == 5'd1) || (op == 5'd13) || (op == 5'd15);
    endfunction

    function automatic logic [3:0] code_flags(input logic [1:0] c);
        case (c)
            2'd0: return 4'h1;
            2'd1: return 4'h5;
            2'd2: return 4'h9;
            default: return 4'h3;
        endcase
    endfunction

    function automatic logic [31:0] mk_cmd(input logic [4:0] op, input logic [3:0] sl,
                                           input logic [15:0] ad, input logic [2:0] bc);
        return {op, 3'b000, sl, ad, 1'b0, bc};
    endfunction

    // full transaction with expectation checks
    task automatic run_txn(input logic [31:0] cmd, input logic [63:0] wd,
                           input logic [1:0] code, input int dly, input bit silent,
                           input int limit, input logic [63:0] rdat);
        logic [4:0]  op = cmd[31:27];
        logic [2:0]  bc = cmd[2:0];
        bit          legal = op_defined(op) && cmd[26:24] == 0 && !cmd[3];
        bit          nd = op_nondata(op);
        bit          late = silent || dly >= limit;
        int          exp_k, k, reqs0;
        logic [3:0]  exp_st;
        logic [63:0] exp_rd;
        logic [31:0] v, r0, r1;
        stub_code = code; stub_delay = dly; stub_silent = silent; stub_data = rdat;
        csr_wr(3'd4, wd[31:0]);
        csr_wr(3'd5, wd[63:32]);
        reqs0 = req_count;
        csr_wr(3'd0, cmd);
        k = 0;
        v = '0;
        while (!v[0] && k < 200) begin
            @(negedge clk);
            k++;
            csr_rd(3'd2, v);
        end
        if (!legal)     begin exp_k = 1;         exp_st = 4'h3; end
        else if (late)  begin exp_k = limit + 1; exp_st = 4'h3; end
        else            begin exp_k = dly + 2;   exp_st = code_flags(code); end
        exp_rd = (legal && !late && code == 2'd0 && op_read(op)) ? (rdat & lane_mask(bc)) : '0;
        check(k == exp_k, "R6 completion latency", 64'(k), 64'(exp_k));
        check(v[3:0] == exp_st, "R5 status flags", 64'(v), 64'(exp_st));
        csr_rd(3'd6, r0);
        csr_rd(3'd7, r1);
        check({r1, r0} == exp_rd, "R3 read lanes", {r1, r0}, exp_rd);
        check(req_count - reqs0 == (legal ? 1 : 0), "R9 request count",
              64'(req_count - reqs0), 64'(legal ? 1 : 0));
        if (legal) begin
            check(cap_op == op && cap_slave == cmd[23:20], "R1 opcode/slave",
                  {cap_op, cap_slave}, {op, cmd[23:20]});
            check(cap_addr == (nd ? 16'h0 : cmd[19:4]) && cap_bcnt == (nd ? 3'd0 : bc),
                  "R8 address/count", {cap_addr, cap_bcnt},
                  {(nd ? 16'h0 : cmd[19:4]), (nd ? 3'd0 : bc)});
            check(cap_nd == nd, "R8 nondata flag", 64'(cap_nd), 64'(nd));
            check(cap_wdata == (nd ? 64'h0 : (wd & lane_mask(bc))), "R2 write lanes",
                  cap_wdata, nd ? 64'h0 : (wd & lane_mask(bc)));
        end
        while (stub_armed) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        csr_rd(3'd0, v); check(v == 0, "R10 command reset", 64'(v), 0);
        csr_rd(3'd1, v); check(v == TMO_RESET, "R10 budget reset", 64'(v), TMO_RESET);
        csr_rd(3'd2, v); check(v == 0, "R10 status reset", 64'(v), 0);
        csr_rd(3'd6, v); check(v == 0, "R10 read lane reset", 64'(v), 0);
        check(txn_req == 0, "R10 request idle", 64'(txn_req), 0);

        // R11 read-only registers
        csr_wr(3'd2, 32'hF);
        csr_wr(3'd6, 32'hDEAD_BEEF);
        csr_wr(3'd7, 32'h1234_5678);
        csr_rd(3'd2, v); check(v == 0, "R11 status write ignored", 64'(v), 0);
        csr_rd(3'd6, v); check(v == 0, "R11 read lane 0 write ignored", 64'(v), 0);
        csr_rd(3'd7, v); check(v == 0, "R11 read lane 1 write ignored", 64'(v), 0);

        // R3 full and single byte reads
        run_txn(mk_cmd(5'd15, 4'h3, 16'h1A40, 3'd7), '0, 2'd0, 1, 0, TMO_RESET,
                64'h8877_6655_4433_2211);
        run_txn(mk_cmd(5'd1, 4'h5, 16'h0210, 3'd0), '0, 2'd0, 0, 0, TMO_RESET,
                64'hFFEE_DDCC_BBAA_9988);
        // R3 a write clears previous read data; R2 partial lanes
        run_txn(mk_cmd(5'd14, 4'h1, 16'h0044, 3'd4), 64'hA1A2_A3A4_A5A6_A7A8,
                2'd0, 2, 0, TMO_RESET, 64'h1111_1111_1111_1111);
        // R5 each response code
        run_txn(mk_cmd(5'd2, 4'h2, 16'h0300, 3'd1), 64'h55AA, 2'd1, 0, 0, TMO_RESET, '0);
        run_txn(mk_cmd(5'd13, 4'h2, 16'h0301, 3'd2), '0, 2'd2, 3, 0, TMO_RESET, 64'hFFFF);
        run_txn(mk_cmd(5'd15, 4'h2, 16'h0302, 3'd3), '0, 2'd3, 1, 0, TMO_RESET, 64'hFFFF);

        // R6 timeouts: budget 5 silent, budget 0 acts as 1, response on last cycle
        csr_wr(3'd1, 32'd5);
        csr_rd(3'd1, v); check(v == 5, "R6 budget readback", 64'(v), 5);
        run_txn(mk_cmd(5'd0, 4'h7, 16'hBEEF, 3'd3), 64'h0102_0304, 2'd0, 0, 1, 5, '0);
        run_txn(mk_cmd(5'd15, 4'h7, 16'hBEEF, 3'd1), '0, 2'd0, 4, 0, 5, 64'hCAFE);
        run_txn(mk_cmd(5'd15, 4'h7, 16'hBEEF, 3'd1), '0, 2'd0, 5, 0, 5, 64'hCAFE);
        csr_wr(3'd1, 32'd0);
        run_txn(mk_cmd(5'd14, 4'h7, 16'h0001, 3'd0), 64'hEE, 2'd0, 0, 1, 1, '0);
        csr_wr(3'd1, 32'd12);

        // R8 non-data commands keep only the slave
        run_txn(mk_cmd(5'd4, 4'h9, 16'hFFFF, 3'd7), 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 0, 12, '0);
        run_txn(mk_cmd(5'd6, 4'hC, 16'h1234, 3'd2), 64'h77, 2'd0, 1, 0, 12, '0);

        // R9 undefined opcode and reserved bits
        run_txn(mk_cmd(5'd9, 4'h1, 16'h0010, 3'd0), '0, 2'd0, 0, 0, 12, '0);
        run_txn(mk_cmd(5'd14, 4'h1, 16'h0010, 3'd0) | 32'h0100_0000, '0, 2'd0, 0, 0, 12, '0);
        run_txn(mk_cmd(5'd15, 4'h1, 16'h0010, 3'd0) | 32'h8, '0, 2'd0, 0, 0, 12, '0);

        // R7 command ignored while pending
        begin
            int r0, k;
            logic [31:0] first = mk_cmd(5'd14, 4'h4, 16'h0505, 3'd1);
            csr_wr(3'd1, 32'd20);
            stub_silent = 1;
            r0 = req_count;
            csr_wr(3'd0, first);
            repeat (3) @(negedge clk);
            csr_wr(3'd0, mk_cmd(5'd15, 4'hA, 16'h0606, 3'd2));
            csr_rd(3'd0, v); check(v == first, "R7 command register held", 64'(v), 64'(first));
            csr_rd(3'd2, v); check(v == 0, "R7 status untouched", 64'(v), 0);
            k = 0; v = 0;
            while (!v[0] && k < 100) begin @(negedge clk); k++; csr_rd(3'd2, v); end
            check(v[3:0] == 4'h3, "R7 first command times out", 64'(v), 3);
            check(req_count - r0 == 1, "R7 single request", 64'(req_count - r0), 1);
            stub_silent = 0;
            csr_wr(3'd1, 32'd12);
        end

        // constrained random traffic
        for (int n = 0; n < 40; n++) begin
            logic [4:0] op;
            logic [4:0] legal_ops [11] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
                                           5'd13, 5'd14, 5'd15, 5'd16};
            if ($urandom_range(7) == 0) op = 5'($urandom_range(7, 12));
            else op = legal_ops[$urandom_range(10)];
            run_txn(mk_cmd(op, 4'($urandom), 16'($urandom), 3'($urandom)),
                    {32'($urandom), 32'($urandom)}, 2'($urandom_range(3)),
                    $urandom_range(14), 0, 12, {32'($urandom), 32'($urandom)});
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule